// File: doc/BRIEF.md
# Multicycle Datapath

This block is the data half of a 32-bit processor that runs each instruction over several clock cycles. It covers register-register arithmetic, loads, stores, add-immediate, branch-if-equal and jump. It holds the program counter, an instruction register, a memory data latch, two operand latches, an ALU result latch and a 32-entry by 32-bit register file. One memory port serves both instruction fetch and data access, and one ALU is reused in every step.

Every steering choice arrives as a separate control input from an external sequencer, and the datapath follows those inputs cycle by cycle. The block returns the instruction opcode and the ALU zero flag so that the sequencer can choose its next step. Memory is outside the block. The block drives the address, the write data and the read and write strobes, and it takes back the read data in the same cycle.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and the instruction register to 0, so `opcode` reads 0.
- R2: `mem_addr` is the program counter when `ctl_addr_sel`=0 and the ALU result latch when it is 1. `mem_wdata` is the B operand latch. `mem_re` and `mem_we` follow `ctl_mem_re` and `ctl_mem_we` in the same cycle.
- R3: The first ALU operand is the program counter when `ctl_srca_sel`=0 and the A latch when it is 1.
- R4: `ctl_srcb_sel` picks the second ALU operand: 0 = B latch, 1 = constant 4, 2 = IR[15:0] sign-extended, 3 = IR[15:0] sign-extended and shifted left by 2.
- R5: `ctl_alu_mode` 0 and 3 add, and 1 subtracts. Mode 2 decodes IR[5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 or 0). Any other function code gives 0.
- R6: `alu_zero` is 1 when the live ALU result is zero. The program counter loads when `ctl_pc_we`=1, or when `ctl_pc_we_cond`=1 and `alu_zero`=1. Otherwise it holds.
- R7: `ctl_pc_src` picks the next program counter: 0 = live ALU result, 1 = ALU result latch, 2 = {PC[31:28], IR[25:0], 2'b00}, 3 = the current value.
- R8: The instruction register loads `mem_rdata` only on an edge where `ctl_ir_we`=1. `opcode` is IR[31:26].
- R9: The A and B latches capture, on every edge, the registers named by IR[25:21] and IR[20:16]. Register 0 reads as zero even after a write to it.
- R10: The register write address is IR[20:16] when `ctl_dst_sel`=0 and IR[15:11] when it is 1. Write data is the ALU result latch when `ctl_wb_sel`=0 and the memory data latch when it is 1. A write takes effect at the edge that ends the cycle in which `ctl_reg_we`=1.
- R11: The ALU result latch and the memory data latch load on every edge, so a value used in a cycle is the one captured at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_pc_we | input | 1 | Unconditional program counter write |
| ctl_pc_we_cond | input | 1 | Program counter write when the ALU result is zero |
| ctl_addr_sel | input | 1 | Memory address source: 0 = PC, 1 = ALU result latch |
| ctl_mem_re | input | 1 | Memory read request |
| ctl_mem_we | input | 1 | Memory write request |
| ctl_ir_we | input | 1 | Instruction register load |
| ctl_wb_sel | input | 1 | Register write data: 0 = ALU result latch, 1 = memory data latch |
| ctl_dst_sel | input | 1 | Register write address: 0 = IR[20:16], 1 = IR[15:11] |
| ctl_reg_we | input | 1 | Register file write |
| ctl_srca_sel | input | 1 | First ALU operand: 0 = PC, 1 = A latch |
| ctl_srcb_sel | input | 2 | Second ALU operand select |
| ctl_alu_mode | input | 2 | ALU operation mode |
| ctl_pc_src | input | 2 | Next program counter source |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (B latch) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| pc | output | 32 | Current program counter |
| opcode | output | 6 | Instruction register bits 31:26 |
| alu_zero | output | 1 | Live ALU result equals zero |

## Verification
The assertions assume that reset is held for at least one edge before any control input matters. They also assume that the control inputs are stable around each rising edge. The bench drives every input only just after a rising edge and samples only after the logic has settled. It places each control value exactly in the cycle in which it is meant to act, and it returns the others to zero between steps. No register is read before the bench has written it.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter logic [31:0] PC_RESET = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_pc_we,
  input  logic        ctl_pc_we_cond,
  input  logic        ctl_addr_sel,
  input  logic        ctl_mem_re,
  input  logic        ctl_mem_we,
  input  logic        ctl_ir_we,
  input  logic        ctl_wb_sel,
  input  logic        ctl_dst_sel,
  input  logic        ctl_reg_we,
  input  logic        ctl_srca_sel,
  input  logic [1:0]  ctl_srcb_sel,
  input  logic [1:0]  ctl_alu_mode,
  input  logic [1:0]  ctl_pc_src,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_re,
  output logic        mem_we,
  output logic [31:0] pc,
  output logic [5:0]  opcode,
  output logic        alu_zero
);

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  logic [31:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_q;
  logic [31:0] rf [0:31];
  logic [31:0] op_a, op_b, alu_res, pc_next, imm_sx, wr_data;
  logic [4:0]  rs, rt, wr_addr;
  logic        pc_load;

  assign rs      = ir_q[25:21];
  assign rt      = ir_q[20:16];
  assign imm_sx  = {{16{ir_q[15]}}, ir_q[15:0]};
  assign wr_addr = ctl_dst_sel ? ir_q[15:11] : rt;
  assign wr_data = ctl_wb_sel ? mdr_q : alu_q;

  assign mem_addr  = ctl_addr_sel ? alu_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_re    = ctl_mem_re;
  assign mem_we    = ctl_mem_we;
  assign pc        = pc_q;
  assign opcode    = ir_q[31:26];

  assign op_a = ctl_srca_sel ? a_q : pc_q;

  always_comb begin
    case (ctl_srcb_sel)
      2'b00:   op_b = b_q;
      2'b01:   op_b = 32'd4;
      2'b10:   op_b = imm_sx;
      default: op_b = {imm_sx[29:0], 2'b00};
    endcase
  end

  always_comb begin
    case (ctl_alu_mode)
      2'b01: alu_res = op_a - op_b;
      2'b10: begin
        case (ir_q[5:0])
          FN_ADD:  alu_res = op_a + op_b;
          FN_SUB:  alu_res = op_a - op_b;
          FN_AND:  alu_res = op_a & op_b;
          FN_OR:   alu_res = op_a | op_b;
          FN_SLT:  alu_res = {31'd0, $signed(op_a) < $signed(op_b)};
          default: alu_res = 32'd0;
        endcase
      end
      default: alu_res = op_a + op_b;
    endcase
  end

  assign alu_zero = (alu_res == 32'd0);

  always_comb begin
    case (ctl_pc_src)
      2'b00:   pc_next = alu_res;
      2'b01:   pc_next = alu_q;
      2'b10:   pc_next = {pc_q[31:28], ir_q[25:0], 2'b00};
      default: pc_next = pc_q;
    endcase
  end

  assign pc_load = ctl_pc_we | (ctl_pc_we_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= PC_RESET;
      ir_q <= 32'd0;
    end else begin
      if (pc_load)   pc_q <= pc_next;
      if (ctl_ir_we) ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    mdr_q <= mem_rdata;
    alu_q <= alu_res;
    a_q   <= (rs == 5'd0) ? 32'd0 : rf[rs];
    b_q   <= (rt == 5'd0) ? 32'd0 : rf[rt];
  end

  always_ff @(posedge clk) begin
    if (ctl_reg_we) rf[wr_addr] <= wr_data;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pc_q == PC_RESET && ir_q == 32'd0));

  p_fetch_step_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_pc_we && ctl_pc_src == 2'b00 && !ctl_srca_sel &&
     ctl_srcb_sel == 2'b01 && ctl_alu_mode == 2'b00)
    |=> pc_q == $past(pc_q) + 32'd4);

  p_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctl_pc_we && !ctl_pc_we_cond) |=> $stable(pc_q));

  p_pc_cond_skip_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctl_pc_we && ctl_pc_we_cond && !alu_zero) |=> $stable(pc_q));

  p_branch_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_pc_we_cond && alu_zero && ctl_pc_src == 2'b01)
    |=> pc_q == $past(alu_q));

  p_ir_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ctl_ir_we |=> $stable(ir_q));

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
    (ir_q[25:21] == 5'd0) |=> a_q == 32'd0);

endmodule

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_pc_we, ctl_pc_we_cond, ctl_addr_sel, ctl_mem_re, ctl_mem_we;
  logic        ctl_ir_we, ctl_wb_sel, ctl_dst_sel, ctl_reg_we, ctl_srca_sel;
  logic [1:0]  ctl_srcb_sel, ctl_alu_mode, ctl_pc_src;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr, mem_wdata, pc;
  logic        mem_re, mem_we, alu_zero;
  logic [5:0]  opcode;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc;
  logic [31:0] res;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_datapath dut (
    .clk(clk), .rst(rst),
    .ctl_pc_we(ctl_pc_we), .ctl_pc_we_cond(ctl_pc_we_cond),
    .ctl_addr_sel(ctl_addr_sel), .ctl_mem_re(ctl_mem_re), .ctl_mem_we(ctl_mem_we),
    .ctl_ir_we(ctl_ir_we), .ctl_wb_sel(ctl_wb_sel), .ctl_dst_sel(ctl_dst_sel),
    .ctl_reg_we(ctl_reg_we), .ctl_srca_sel(ctl_srca_sel),
    .ctl_srcb_sel(ctl_srcb_sel), .ctl_alu_mode(ctl_alu_mode), .ctl_pc_src(ctl_pc_src),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_we(mem_we), .pc(pc), .opcode(opcode), .alu_zero(alu_zero)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ctl_pc_we = 0; ctl_pc_we_cond = 0; ctl_addr_sel = 0; ctl_mem_re = 0;
    ctl_mem_we = 0; ctl_ir_we = 0; ctl_wb_sel = 0; ctl_dst_sel = 0;
    ctl_reg_we = 0; ctl_srca_sel = 0; ctl_srcb_sel = 0; ctl_alu_mode = 0;
    ctl_pc_src = 0;
  endtask

  task automatic load_ir(input logic [31:0] w);
    mem_rdata = w; ctl_ir_we = 1;
    tick();
    ctl_ir_we = 0;
  endtask

  task automatic put_reg(input logic [4:0] r, input logic [31:0] v);
    load_ir({6'h23, 5'd0, r, 16'h0000});
    mem_rdata = v;
    tick();
    ctl_wb_sel = 1; ctl_dst_sel = 0; ctl_reg_we = 1;
    tick();
    idle();
  endtask

  task automatic select(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] low);
    load_ir({6'h00, rs, rt, low});
    tick();
  endtask

  task automatic alu_run(input logic sa, input logic [1:0] sb, input logic [1:0] md,
                         output logic [31:0] r);
    ctl_srca_sel = sa; ctl_srcb_sel = sb; ctl_alu_mode = md;
    tick();
    idle();
    ctl_addr_sel = 1;
    #1;
    r = mem_addr;
    ctl_addr_sel = 0;
  endtask

  task automatic t_reset();
    idle(); mem_rdata = 32'h0; rst = 1;
    tick(); tick();
    rst = 0;
    check32("R1 reset pc", pc, 32'h0);
    check32("R1 reset opcode", {26'd0, opcode}, 32'h0);
    exp_pc = 32'h0;
  endtask

  task automatic t_fetch();
    mem_rdata = 32'h8C22_0004;
    #1;
    check32("R2 fetch address is pc", mem_addr, exp_pc);
    ctl_mem_re = 1;
    #1;
    check32("R2 read strobe", {31'd0, mem_re}, 32'd1);
    ctl_ir_we = 1; ctl_pc_we = 1; ctl_srcb_sel = 2'b01; ctl_alu_mode = 0; ctl_pc_src = 0;
    tick();
    idle();
    exp_pc = exp_pc + 4;
    check32("R4 fetch pc plus 4", pc, exp_pc);
    check32("R8 opcode loaded", {26'd0, opcode}, 32'h23);
  endtask

  task automatic t_regs();
    put_reg(5'd1, 32'd7);
    put_reg(5'd2, 32'd12);
    put_reg(5'd3, 32'hFFFF_FFF0);
    put_reg(5'd0, 32'd55);
    select(5'd1, 5'd2, 16'h0);
    check32("R9 B latch reads r2", mem_wdata, 32'd12);
    select(5'd0, 5'd3, 16'h0);
    check32("R9 B latch reads r3", mem_wdata, 32'hFFFF_FFF0);
    alu_run(1, 2'b10, 2'b00, res);
    check32("R9 r0 reads zero", res, 32'h0);
  endtask

  task automatic t_rtype();
    logic [5:0]  fn [8];
    logic [4:0]  sa [8];
    logic [4:0]  sb [8];
    logic [31:0] ex [8];
    fn[0] = 6'h20; sa[0] = 1; sb[0] = 2; ex[0] = 32'd19;
    fn[1] = 6'h22; sa[1] = 1; sb[1] = 2; ex[1] = 32'hFFFF_FFFB;
    fn[2] = 6'h24; sa[2] = 1; sb[2] = 2; ex[2] = 32'd4;
    fn[3] = 6'h25; sa[3] = 1; sb[3] = 2; ex[3] = 32'd15;
    fn[4] = 6'h2A; sa[4] = 1; sb[4] = 2; ex[4] = 32'd1;
    fn[5] = 6'h2A; sa[5] = 3; sb[5] = 1; ex[5] = 32'd1;
    fn[6] = 6'h2A; sa[6] = 1; sb[6] = 3; ex[6] = 32'd0;
    fn[7] = 6'h3F; sa[7] = 1; sb[7] = 2; ex[7] = 32'd0;
    for (int i = 0; i < 8; i++) begin
      select(sa[i], sb[i], {5'd4, 5'd0, fn[i]});
      alu_run(1, 2'b00, 2'b10, res);
      check32($sformatf("R5 function code %h case %0d", fn[i], i), res, ex[i]);
    end
    select(5'd1, 5'd2, 16'h0);
    alu_run(1, 2'b00, 2'b00, res);
    check32("R5 mode 0 adds", res, 32'd19);
    alu_run(1, 2'b00, 2'b01, res);
    check32("R5 mode 1 subtracts", res, 32'hFFFF_FFFB);
    alu_run(1, 2'b00, 2'b11, res);
    check32("R5 mode 3 adds", res, 32'd19);
  endtask

  task automatic t_operands();
    select(5'd1, 5'd2, 16'hFFFE);
    alu_run(1, 2'b10, 2'b00, res);
    check32("R4 sign-extended immediate", res, 32'd5);
    alu_run(1, 2'b01, 2'b00, res);
    check32("R4 constant four", res, 32'd11);
    alu_run(0, 2'b11, 2'b00, res);
    check32("R3 R4 pc plus shifted immediate", res, exp_pc - 32'd8);
  endtask

  task automatic t_writeback();
    select(5'd1, 5'd2, {5'd4, 5'd0, 6'h20});
    ctl_srca_sel = 1; ctl_srcb_sel = 0; ctl_alu_mode = 2'b10;
    tick();
    idle();
    ctl_reg_we = 1; ctl_dst_sel = 1; ctl_wb_sel = 0;
    tick();
    idle();
    select(5'd0, 5'd4, 16'h0);
    check32("R10 rd field write of ALU latch", mem_wdata, 32'd19);
    select(5'd1, 5'd5, 16'h0003);
    ctl_srca_sel = 1; ctl_srcb_sel = 2'b10;
    tick();
    idle();
    ctl_reg_we = 1; ctl_dst_sel = 0; ctl_wb_sel = 0;
    tick();
    idle();
    select(5'd0, 5'd5, 16'h0);
    check32("R10 rt field write of ALU latch", mem_wdata, 32'd10);
    load_ir({6'h23, 5'd0, 5'd6, 16'h0});
    mem_rdata = 32'hA1A1_0001;
    tick();
    mem_rdata = 32'hB2B2_0002;
    ctl_reg_we = 1; ctl_wb_sel = 1; ctl_dst_sel = 0;
    tick();
    idle();
    select(5'd0, 5'd6, 16'h0);
    check32("R11 memory latch holds previous read", mem_wdata, 32'hA1A1_0001);
  endtask

  task automatic t_branch();
    select(5'd1, 5'd1, 16'h0004);
    ctl_srcb_sel = 2'b11;
    tick();
    ctl_srca_sel = 1; ctl_srcb_sel = 0; ctl_alu_mode = 2'b01;
    ctl_pc_we_cond = 1; ctl_pc_src = 2'b01;
    #1;
    check32("R6 zero flag equal operands", {31'd0, alu_zero}, 32'd1);
    tick();
    idle();
    exp_pc = exp_pc + 32'd16;
    check32("R6 R7 branch taken", pc, exp_pc);
    select(5'd1, 5'd2, 16'h0004);
    ctl_srcb_sel = 2'b11;
    tick();
    ctl_srca_sel = 1; ctl_srcb_sel = 0; ctl_alu_mode = 2'b01;
    ctl_pc_we_cond = 1; ctl_pc_src = 2'b01;
    #1;
    check32("R6 zero flag unequal operands", {31'd0, alu_zero}, 32'd0);
    tick();
    idle();
    check32("R6 branch not taken", pc, exp_pc);
    ctl_srcb_sel = 2'b01; ctl_pc_src = 2'b00;
    tick();
    idle();
    check32("R6 no write enable holds pc", pc, exp_pc);
  endtask

  task automatic t_pcsrc();
    select(5'd3, 5'd0, 16'h0);
    ctl_srca_sel = 1; ctl_srcb_sel = 2'b10; ctl_pc_we = 1; ctl_pc_src = 2'b00;
    tick();
    idle();
    exp_pc = 32'hFFFF_FFF0;
    check32("R7 live ALU result", pc, exp_pc);
    load_ir({6'h02, 26'h000_0123});
    ctl_pc_we = 1; ctl_pc_src = 2'b10;
    tick();
    idle();
    exp_pc = 32'hF000_048C;
    check32("R7 jump target", pc, exp_pc);
    ctl_pc_we = 1; ctl_pc_src = 2'b11;
    tick();
    idle();
    check32("R7 source 3 keeps pc", pc, exp_pc);
  endtask

  task automatic t_ir_hold();
    mem_rdata = 32'hFFFF_FFFF;
    tick();
    check32("R8 opcode held without load", {26'd0, opcode}, 32'h02);
  endtask

  task automatic t_store();
    select(5'd1, 5'd2, 16'h0010);
    ctl_srca_sel = 1; ctl_srcb_sel = 2'b10;
    tick();
    idle();
    ctl_addr_sel = 1; ctl_mem_we = 1;
    #1;
    check32("R2 data address from ALU latch", mem_addr, 32'h17);
    check32("R2 write data is B latch", mem_wdata, 32'd12);
    check32("R2 write strobe", {30'd0, mem_we, mem_re}, 32'b10);
    idle();
  endtask

  task automatic t_reset_again();
    rst = 1;
    tick();
    rst = 0;
    check32("R1 reset during run pc", pc, 32'h0);
    check32("R1 reset during run opcode", {26'd0, opcode}, 32'h0);
  endtask

  logic finished = 1'b0;

  initial begin
    t_reset();
    t_fetch();
    t_regs();
    t_rtype();
    t_operands();
    t_writeback();
    t_branch();
    t_pcsrc();
    t_ir_hold();
    t_store();
    t_reset_again();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule